// File: doc/BRIEF.md
# Maskable Event Latch with Write-One-to-Clear Status

This block collects hardware event pulses into a small status register and raises a single level-sensitive interrupt request when a latched event is not masked. Software reaches it through a plain word-addressed register port: a write strobe with address and data, and read data that follows the address combinationally.

Software cannot write the mask directly. It clears mask bits by writing ones to an unmask register, and sets mask bits by writing ones to a separate mask-set register. Neither register stores anything. After reset every source is masked, so no request can leave the block until software unmasks a source. The number of implemented sources is a parameter; the default is one source on bit 0.

Top module: `irqm_ctrl`

## Requirements
- R1: After reset, status reads 0, the mask reads all implemented bits set (0x1 by default) and `irq` is low.
- R2: A write to offset 0x0 clears each status bit whose data bit is 1. Status bits whose data bit is 0 keep their value.
- R3: An `evt` bit that is high at a clock edge sets the matching status bit at that edge.
- R4: If an event and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R5: The mask is read at offset 0x4. Bus writes to offset 0x4 leave it unchanged.
- R6: A write to offset 0x8 clears each mask bit whose data bit is 1 and leaves the other mask bits as they were.
- R7: A write to offset 0xC sets each mask bit whose data bit is 1 and leaves the other mask bits as they were.
- R8: Offsets 0x8 and 0xC always read as zero.
- R9: `irq` is registered. It equals the OR over all bits of (status AND NOT mask), and it changes on the same clock edge as the status or mask change that causes it, one cycle after the write or event is presented.
- R10: Any offset other than 0x0, 0x4, 0x8 and 0xC reads as zero.
- R11: Data bits above the implemented source count are ignored on write and read as zero in status and mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| evt | input | NUM_SRC | Hardware event pulses, one per source |
| irq | output | 1 | Level interrupt request |

## Verification
An event that arrives while the source is masked has to set status without raising the request. This separates the latching path from the request path. Clearing writes are tried with zero data, with ones, and together with an event in the same cycle, to tell a real write-one-to-clear from a plain store and to show which side wins. Unmask and mask-set writes are tried with zero data, with all ones, and with only an unimplemented bit set, so that a stored write or a stray width becomes visible on the mask readback. The request is sampled in the middle of the causing cycle and again after the edge, to pin down its single cycle of latency.

// File: rtl/irqm_pkg.sv
package irqm_pkg;

  localparam int OFF_STAT = 'h0;
  localparam int OFF_MASK = 'h4;
  localparam int OFF_EN   = 'h8;
  localparam int OFF_DIS  = 'hC;

  typedef enum logic [2:0] {
    SEL_STAT,
    SEL_MASK,
    SEL_EN,
    SEL_DIS,
    SEL_NONE
  } reg_sel_e;

endpackage

// File: rtl/irqm_decode.sv
module irqm_decode
  import irqm_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);

  always_comb begin
    if (addr == ADDR_W'(OFF_STAT))      sel = SEL_STAT;
    else if (addr == ADDR_W'(OFF_MASK)) sel = SEL_MASK;
    else if (addr == ADDR_W'(OFF_EN))   sel = SEL_EN;
    else if (addr == ADDR_W'(OFF_DIS))  sel = SEL_DIS;
    else                                sel = SEL_NONE;
  end

endmodule

// File: rtl/irqm_status.sv
module irqm_status #(
  parameter int NUM_SRC = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt,
  input  logic [NUM_SRC-1:0] clr_bits,
  output logic [NUM_SRC-1:0] stat_d,
  output logic [NUM_SRC-1:0] stat_q
);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    // an event at the same edge as a clear leaves the bit set
    assign stat_d[i] = evt[i] | (stat_q[i] & ~clr_bits[i]);

    always_ff @(posedge clk) begin
      if (!rst_n) stat_q[i] <= 1'b0;
      else        stat_q[i] <= stat_d[i];
    end
  end

endmodule

// File: rtl/irqm_mask.sv
module irqm_mask #(
  parameter int NUM_SRC = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] unmask_bits,
  input  logic [NUM_SRC-1:0] setmask_bits,
  output logic [NUM_SRC-1:0] mask_d,
  output logic [NUM_SRC-1:0] mask_q
);

  assign mask_d = (mask_q & ~unmask_bits) | setmask_bits;

  always_ff @(posedge clk) begin
    if (!rst_n) mask_q <= '1;
    else        mask_q <= mask_d;
  end

endmodule

// File: rtl/irqm_ctrl.sv
module irqm_ctrl
  import irqm_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 32,
  parameter int NUM_SRC = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NUM_SRC-1:0] evt,
  output logic              irq
);

  reg_sel_e           sel;
  logic [NUM_SRC-1:0] wbits;
  logic [NUM_SRC-1:0] clr_bits, unmask_bits, setmask_bits;
  logic [NUM_SRC-1:0] stat_d, stat_q, mask_d, mask_q;
  logic               irq_q;

  irqm_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .sel  (sel)
  );

  assign wbits        = bus_wdata[NUM_SRC-1:0];
  assign clr_bits     = (bus_wr && sel == SEL_STAT) ? wbits : '0;
  assign unmask_bits  = (bus_wr && sel == SEL_EN)   ? wbits : '0;
  assign setmask_bits = (bus_wr && sel == SEL_DIS)  ? wbits : '0;

  irqm_status #(.NUM_SRC(NUM_SRC)) u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (evt),
    .clr_bits (clr_bits),
    .stat_d   (stat_d),
    .stat_q   (stat_q)
  );

  irqm_mask #(.NUM_SRC(NUM_SRC)) u_mask (
    .clk          (clk),
    .rst_n        (rst_n),
    .unmask_bits  (unmask_bits),
    .setmask_bits (setmask_bits),
    .mask_d       (mask_d),
    .mask_q       (mask_q)
  );

  // request follows the next state so it moves on the same edge as status/mask
  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |(stat_d & ~mask_d);
  end
  assign irq = irq_q;

  always_comb begin
    unique case (sel)
      SEL_STAT: bus_rdata = DATA_W'(stat_q);
      SEL_MASK: bus_rdata = DATA_W'(mask_q);
      default:  bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/irqm_ctrl_chk.sv
module irqm_ctrl_chk
  import irqm_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 32,
  parameter int NUM_SRC = 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_wr,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [DATA_W-1:0]  bus_wdata,
  input logic [DATA_W-1:0]  bus_rdata,
  input logic [NUM_SRC-1:0] evt,
  input logic [NUM_SRC-1:0] stat_q,
  input logic [NUM_SRC-1:0] mask_q,
  input logic               irq
);

  p_evt_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    evt[0] |=> stat_q[0]);

  p_mask_ro_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(OFF_MASK)) |=> $stable(mask_q));

  p_unmask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(OFF_EN) && bus_wdata[0]) |=> !mask_q[0]);

  p_setmask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(OFF_DIS) && bus_wdata[0]) |=> mask_q[0]);

  p_wo_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(OFF_EN) || bus_addr == ADDR_W'(OFF_DIS)) |-> bus_rdata == '0);

  p_irq_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq == |(stat_q & ~mask_q));

  p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(OFF_STAT) && bus_wdata[0] && !evt[0]) |=> !stat_q[0]);

endmodule

bind irqm_ctrl irqm_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SRC(NUM_SRC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt(evt),
  .stat_q(stat_q), .mask_q(mask_q), .irq(irq)
);

// File: tb/sim_irqm_ctrl.sv
`timescale 1ns/1ps
module sim_irqm_ctrl;

  typedef struct {
    logic [3:0]  addr;
    logic [31:0] rdata;
    logic        irq;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [0:0]  evt = '0;
  logic        irq;

  item_t q[$];
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irqm_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt(evt), .irq(irq)
  );

  // monitor: pop and compare away from the active edge
  always @(negedge clk) begin
    item_t it;
    if (q.size() != 0) begin
      it = q.pop_front();
      checks++;
      if (bus_rdata !== it.rdata || irq !== it.irq) begin
        fails++;
        $display("FAIL %s: addr=0x%0h rdata=0x%0h irq=%0b expected rdata=0x%0h irq=%0b",
                 it.tag, it.addr, bus_rdata, irq, it.rdata, it.irq);
      end
    end
  end

  task automatic expect_now(input logic [3:0] a, input logic [31:0] d,
                            input logic i, input string tag);
    item_t it;
    bus_addr = a;
    it.addr = a; it.rdata = d; it.irq = i; it.tag = tag;
    q.push_back(it);
    @(negedge clk);
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] d,
                    input logic i, input string tag);
    @(posedge clk); #1;
    bus_wr = 1'b0; evt = '0;
    expect_now(a, d, i, tag);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic e);
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; evt = e;
    @(posedge clk); #1;
    bus_wr = 1'b0; bus_wdata = '0; evt = '0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd(4'h0, 32'h0, 1'b0, "R1 status after reset");
    rd(4'h4, 32'h1, 1'b0, "R1 mask after reset");
    // R8 write-only registers read zero, R10 unmapped offsets
    rd(4'h8, 32'h0, 1'b0, "R8 unmask reg reads zero");
    rd(4'hC, 32'h0, 1'b0, "R8 setmask reg reads zero");
    rd(4'h1, 32'h0, 1'b0, "R10 unaligned offset reads zero");
    rd(4'h6, 32'h0, 1'b0, "R10 unmapped offset reads zero");

    // R3 event latches while masked, request stays low (R9)
    wr(4'h6, 32'h0, 1'b1);
    rd(4'h0, 32'h1, 1'b0, "R3 event sets status while masked");

    // R5 mask ignores direct writes
    wr(4'h4, 32'h0, 1'b0);
    rd(4'h4, 32'h1, 1'b0, "R5 mask unchanged by direct write");

    // R6 zero data leaves mask, ones clear it; R11 upper bits read zero
    wr(4'h8, 32'h0, 1'b0);
    rd(4'h4, 32'h1, 1'b0, "R6 unmask with zero data no effect");
    wr(4'h8, 32'hFFFF_FFFF, 1'b0);
    rd(4'h4, 32'h0, 1'b1, "R6 unmask clears mask, R9 irq rises");
    rd(4'h8, 32'h0, 1'b1, "R8 unmask reg still reads zero");

    // R2 write-one-to-clear
    wr(4'h0, 32'h0, 1'b0);
    rd(4'h0, 32'h1, 1'b1, "R2 write of zero keeps status");
    wr(4'h0, 32'hFFFF_FFFE, 1'b0);
    rd(4'h0, 32'h1, 1'b1, "R11 upper data bits do not clear status");
    wr(4'h0, 32'h1, 1'b0);
    rd(4'h0, 32'h0, 1'b0, "R2 write of one clears status, irq falls");

    // R4 event wins over clear in the same cycle
    wr(4'h0, 32'h1, 1'b1);
    rd(4'h0, 32'h1, 1'b1, "R4 event beats same-cycle clear");
    wr(4'h0, 32'h1, 1'b0);
    rd(4'h0, 32'h0, 1'b0, "R2 clear after R4 case");

    // R9 latency: request low during event cycle, high after the edge
    @(posedge clk); #1;
    evt = 1'b1;
    expect_now(4'h0, 32'h0, 1'b0, "R9 irq not yet high in event cycle");
    @(posedge clk); #1;
    evt = 1'b0;
    expect_now(4'h0, 32'h1, 1'b1, "R9 irq high one cycle after event");

    // R11 setmask with only unimplemented bit
    wr(4'hC, 32'h2, 1'b0);
    rd(4'h4, 32'h0, 1'b1, "R11 unimplemented mask bit ignored");

    // R7 setmask, R9 latency on the falling side
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_addr = 4'hC; bus_wdata = 32'h1;
    expect_now(4'hC, 32'h0, 1'b1, "R9 irq still high during setmask cycle");
    @(posedge clk); #1;
    bus_wr = 1'b0; bus_wdata = '0;
    expect_now(4'h4, 32'h1, 1'b0, "R7 setmask sets mask, irq falls");
    rd(4'hC, 32'h0, 1'b0, "R8 setmask reg still reads zero");
    rd(4'h0, 32'h1, 1'b0, "R7 status kept while masked");

    // R1 reset again restores defaults
    @(posedge clk); #1 rst_n = 1'b0;
    @(posedge clk); #1 rst_n = 1'b1;
    expect_now(4'h4, 32'h1, 1'b0, "R1 mask after second reset");
    rd(4'h0, 32'h0, 1'b0, "R1 status after second reset");

    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule